// File: doc/BRIEF.md
# Ring-Mirrored Memory Node

This block is one node on a one-way ring of nodes that keep identical copies of a shared memory. When the local bus writes a word, the node stores it in its own RAM. It also queues the word for the ring, tagged with the node's 8-bit ID and with the offset of the word relative to the node's base address. Because only that relative offset travels, each node may be mapped at a different bus address.

A word coming in from the ring is handled by its tag. If the tag is the node's own, the word has gone all the way round: it is taken off the ring and a sticky flag is raised, which software can use to time the loop. Any other word is queued in a receive FIFO. From there it is written into local RAM and also passed on toward the next node. Local writes and forwarded traffic share the RAM write port and the transmit FIFO, and the local side wins a tie.

An optional redundant mode sends every word twice, and the receiver picks the better of the two copies. A status byte reports the FIFO levels and the error and loop flags. The physical link is a parallel word stream. Each word carries a valid flag and a parity bit, and the outgoing side has a ready handshake.

Top module: `rmesh_node`

## Requirements
- R1: A local RAM write (`busWrEn`=1, `busSel`=0, transmit FIFO not full) stores `busWrData` at `busAddr` and queues one link word. The link word layout, from LSB up, is: data `[15:0]`, offset `[23:16]`, tag `[31:24]` set to `nodeId`, kind `[32]` (0 = data, 1 = status), parity `[33]`. Parity is even over bits `[32:0]`.
- R2: A good received word whose tag equals `nodeId` is not stored and not forwarded. It sets the own-data flag, status bit 2, which stays set until a local status write with bit 2 at 0.
- R3: A good received data word with a foreign tag is written to RAM at its offset and is sent on unchanged.
- R4: A local write in a cycle takes the RAM and transmit FIFO, and the head of the receive FIFO waits. Link output order is therefore local words first.
- R5: A received word whose parity is wrong sets the bad-data flag, status bit 3, outside redundant mode. That word is dropped. The flag stays set until a local status write with bit 3 at 0.
- R6: With `redundant`=1, received words come in pairs. The first copy is kept if its parity is good, and otherwise the second copy is kept. An error in either copy sets the bad-data flag.
- R7: With `redundant`=1, each transmit FIFO entry is presented on `txWord` for two accepted handshakes before it is removed.
- R8: While the transmit FIFO is full, a local write gets `busErr`=1 and `busAck`=0. It changes neither RAM nor the queue.
- R9: `status` bits from MSB down are:
  - LED
  - receive half-full (low when the count is at least DEPTH/2)
  - transmit over-half (low when the count is above DEPTH/2)
  - transmit empty (low when empty)
  - bad data
  - own data
  - `maskErr`
  - NOT `redundant`

  With both inputs at 0, the reset value is 0xE1.
- R10: A received status-kind word with a foreign tag is forwarded. It does not touch local RAM or `status`.
- R11: The LED bit resets to 1 and changes only on a local status write, which loads it from data bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeId | input | 8 | This node's ring ID |
| redundant | input | 1 | Double-send mode |
| maskErr | input | 1 | Reported in status bit 1 |
| busWrEn | input | 1 | Local write request |
| busSel | input | 1 | 0 = RAM, 1 = status register |
| busAddr | input | 8 | Relative word offset |
| busWrData | input | 16 | Write data (status uses the low byte) |
| busAck | output | 1 | Write accepted this cycle |
| busErr | output | 1 | Write refused, transmit FIFO full |
| rdAddr | input | 8 | RAM read offset |
| rdData | output | 16 | RAM read data, one cycle later |
| status | output | 8 | Status byte |
| rxValid | input | 1 | Incoming link word valid |
| rxWord | input | 34 | Incoming link word |
| txValid | output | 1 | Outgoing link word valid |
| txWord | output | 34 | Outgoing link word |
| txReady | input | 1 | Next node accepts the outgoing word |

## Verification
The bench lines up a foreign ring word and two local writes so that the forwarded word reaches the drain stage while the bus is still busy. A design that let ring traffic win would show the wrong output order, and the wrong final value at the offset both sources write.

It returns the node's own word and checks that it neither forwards nor stores it. A design comparing the wrong field would echo the word round the ring forever.

It fills the transmit FIFO to exactly its depth and checks the half-full flags at the counts on either side of each threshold. An off-by-one would move a flag by one word, and a missing full check would accept a write it should refuse.

In redundant mode it sends a good-then-bad pair and a bad-then-good pair. A receiver picking the wrong copy stores the corrupted data. A foreign status word is also checked, since a design applying it would turn the LED off.

// File: rtl/rmesh_pkg.sv
package rmesh_pkg;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic holdFirst;   // latch first copy of a redundant pair
    logic rxPush;      // push a received word into the receive FIFO
    logic rxPushHeld;  // push source is the held first copy
    logic rxPop;       // drain receive FIFO head
    logic ramWeLocal;  // RAM write from the bus
    logic ramWeRx;     // RAM write from the receive FIFO head
    logic txPushLocal; // queue a locally built word
    logic txPushRx;    // queue the receive FIFO head
    logic txPop;       // remove the transmit FIFO head
  } strobe_t;
endpackage

// File: rtl/rmesh_fifo.sv
module rmesh_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 512,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (!full || pop));
  a_r3_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
endmodule

// File: rtl/rmesh_ctrl.sv
module rmesh_ctrl
  import rmesh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    redundant,
  input  logic    maskErr,
  input  logic    busWrEn,
  input  logic    busSel,
  input  logic    wrLed,
  input  logic    wrBad,
  input  logic    wrOwn,
  input  logic    txReady,
  input  logic    rxValid,
  input  logic    curGood,
  input  logic    curOwn,
  input  logic    heldOwn,
  input  logic    rxEmpty,
  input  logic    rxFull,
  input  logic    rxHeadKind,
  input  logic    rxHalf,
  input  logic    txEmpty,
  input  logic    txFull,
  input  logic    txOver,
  output strobe_t stb,
  output logic    busAck,
  output logic    busErr,
  output logic    txValid,
  output logic [7:0] status
);
  logic rxPhase, firstGood, txPhase;
  logic ledBit, badBit, ownBit;
  logic badSet, ownSet, takeWord, takeHeld, takeOwn;
  logic localGo, rxGo, csrWr;

  // receive acceptance and copy selection
  always_comb begin
    badSet   = 1'b0;
    takeWord = 1'b0;
    takeHeld = 1'b0;
    takeOwn  = 1'b0;
    stb.holdFirst = 1'b0;
    if (rxValid) begin
      if (!redundant) begin
        badSet   = !curGood;
        takeWord = curGood;
        takeOwn  = curOwn;
      end else if (!rxPhase) begin
        stb.holdFirst = 1'b1;
        badSet = !curGood;
      end else begin
        badSet = !curGood;
        if (firstGood) begin
          takeWord = 1'b1;
          takeHeld = 1'b1;
          takeOwn  = heldOwn;
        end else if (curGood) begin
          takeWord = 1'b1;
          takeOwn  = curOwn;
        end
      end
    end
    ownSet         = takeWord && takeOwn;
    stb.rxPush     = takeWord && !takeOwn && !rxFull;
    stb.rxPushHeld = takeHeld;
  end

  // arbitration: a local write owns RAM and transmit FIFO for its cycle
  always_comb begin
    localGo = busWrEn && !txFull;
    rxGo    = !busWrEn && !rxEmpty && !txFull;
    csrWr   = localGo && busSel;
    busAck  = localGo;
    busErr  = busWrEn && txFull;
    stb.ramWeLocal  = localGo && !busSel;
    stb.txPushLocal = localGo;
    stb.rxPop       = rxGo;
    stb.txPushRx    = rxGo;
    stb.ramWeRx     = rxGo && !rxHeadKind;
    txValid         = !txEmpty;
    stb.txPop       = !txEmpty && txReady && (!redundant || txPhase);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPhase   <= 1'b0;
      firstGood <= 1'b0;
      txPhase   <= 1'b0;
    end else begin
      if (!redundant) begin
        rxPhase <= 1'b0;
        txPhase <= 1'b0;
      end else begin
        if (rxValid) rxPhase <= !rxPhase;
        if (rxValid && !rxPhase) firstGood <= curGood;
        if (!txEmpty && txReady) txPhase <= !txPhase;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledBit <= 1'b1;
      badBit <= 1'b0;
      ownBit <= 1'b0;
    end else begin
      if (csrWr) ledBit <= wrLed;
      badBit <= badSet || (badBit && !(csrWr && !wrBad));
      ownBit <= ownSet || (ownBit && !(csrWr && !wrOwn));
    end
  end

  assign status = {ledBit, !rxHalf, !txOver, !txEmpty, badBit, ownBit, maskErr, !redundant};

  a_r2_own_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ownBit && !(busWrEn && busSel && !txFull && !wrOwn)) |=> ownBit);
  a_r11_led_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busSel) |=> $stable(ledBit));
  a_r8_err_only_when_full: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (txFull && !busAck));
endmodule

// File: rtl/rmesh_datapath.sv
module rmesh_datapath
  import rmesh_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 8,
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  localparam int OFF_LO  = DATA_W,
  localparam int TAG_LO  = DATA_W + OFF_W,
  localparam int KIND_B  = TAG_LO + TAG_W,
  localparam int PAR_B   = KIND_B + 1,
  localparam int WW      = PAR_B + 1,
  localparam int RAM_D   = 1 << OFF_W,
  localparam int TXCW    = $clog2(TX_DEPTH + 1),
  localparam int RXCW    = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [TAG_W-1:0]  nodeId,
  input  logic              busSel,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [OFF_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [WW-1:0]     rxWord,
  output logic [WW-1:0]     txWord,
  output logic              curGood,
  output logic              curOwn,
  output logic              heldOwn,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              rxHeadKind,
  output logic              rxHalf,
  output logic              txEmpty,
  output logic              txFull,
  output logic              txOver
);
  localparam logic [RXCW-1:0] RX_HALF = RXCW'(RX_DEPTH / 2);
  localparam logic [TXCW-1:0] TX_HALF = TXCW'(TX_DEPTH / 2);

  logic [DATA_W-1:0] ram [RAM_D];
  logic [WW-1:0] heldWord, rxHead, localWord, rxPushData, txPushData;
  logic [RXCW-1:0] rxCount;
  logic [TXCW-1:0] txCount;
  logic [WW-2:0] localBody;

  assign localBody = {busSel, nodeId, busAddr, busWrData};
  assign localWord = {^localBody, localBody};

  assign curGood    = ~^rxWord;
  assign curOwn     = rxWord[KIND_B-1:TAG_LO] == nodeId;
  assign heldOwn    = heldWord[KIND_B-1:TAG_LO] == nodeId;
  assign rxHeadKind = rxHead[KIND_B];
  assign rxHalf     = rxCount >= RX_HALF;
  assign txOver     = txCount > TX_HALF;

  assign rxPushData = stb.rxPushHeld ? heldWord : rxWord;
  assign txPushData = stb.txPushLocal ? localWord : rxHead;

  always_ff @(posedge clk) begin
    if (!rstN) heldWord <= '0;
    else if (stb.holdFirst) heldWord <= rxWord;
  end

  always_ff @(posedge clk) begin
    if (stb.ramWeLocal)   ram[busAddr] <= busWrData;
    else if (stb.ramWeRx) ram[rxHead[TAG_LO-1:OFF_LO]] <= rxHead[DATA_W-1:0];
    rdData <= ram[rdAddr];
  end

  rmesh_fifo #(.WIDTH(WW), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pushData(rxPushData),
    .pop(stb.rxPop), .headData(rxHead), .empty(rxEmpty), .full(rxFull),
    .count(rxCount));

  rmesh_fifo #(.WIDTH(WW), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(stb.txPushLocal || stb.txPushRx),
    .pushData(txPushData), .pop(stb.txPop), .headData(txWord),
    .empty(txEmpty), .full(txFull), .count(txCount));

  a_r4_single_ram_writer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ramWeLocal, stb.ramWeRx}));
  a_r4_single_tx_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.txPushLocal, stb.txPushRx}));
endmodule

// File: rtl/rmesh_node.sv
module rmesh_node
  import rmesh_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 8,
  parameter int TX_DEPTH = 512,
  parameter int RX_DEPTH = 512,
  localparam int WW = DATA_W + OFF_W + TAG_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  nodeId,
  input  logic              redundant,
  input  logic              maskErr,
  input  logic              busWrEn,
  input  logic              busSel,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              busAck,
  output logic              busErr,
  input  logic [OFF_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        status,
  input  logic              rxValid,
  input  logic [WW-1:0]     rxWord,
  output logic              txValid,
  output logic [WW-1:0]     txWord,
  input  logic              txReady
);
  strobe_t stb;
  logic curGood, curOwn, heldOwn, rxEmpty, rxFull, rxHeadKind, rxHalf;
  logic txEmpty, txFull, txOver;

  rmesh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .redundant(redundant), .maskErr(maskErr),
    .busWrEn(busWrEn), .busSel(busSel),
    .wrLed(busWrData[7]), .wrBad(busWrData[3]), .wrOwn(busWrData[2]),
    .txReady(txReady), .rxValid(rxValid), .curGood(curGood), .curOwn(curOwn),
    .heldOwn(heldOwn), .rxEmpty(rxEmpty), .rxFull(rxFull), .rxHeadKind(rxHeadKind),
    .rxHalf(rxHalf), .txEmpty(txEmpty), .txFull(txFull), .txOver(txOver),
    .stb(stb), .busAck(busAck), .busErr(busErr), .txValid(txValid), .status(status));

  rmesh_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W), .TX_DEPTH(TX_DEPTH),
                   .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nodeId(nodeId), .busSel(busSel),
    .busAddr(busAddr), .busWrData(busWrData), .rdAddr(rdAddr), .rdData(rdData),
    .rxWord(rxWord), .txWord(txWord), .curGood(curGood), .curOwn(curOwn),
    .heldOwn(heldOwn), .rxEmpty(rxEmpty), .rxFull(rxFull), .rxHeadKind(rxHeadKind),
    .rxHalf(rxHalf), .txEmpty(txEmpty), .txFull(txFull), .txOver(txOver));
endmodule

// File: tb/rmesh_node_bench.sv
module rmesh_node_bench;
  localparam int WW = 34;
  localparam int DEPTH = 512;
  localparam logic [7:0] ME = 8'h2A;
  localparam logic [7:0] OTHER = 8'h05;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic redundant = 1'b0, maskErr = 1'b0;
  logic busWrEn = 1'b0, busSel = 1'b0;
  logic [7:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic busAck, busErr;
  logic [7:0] rdAddr = '0;
  logic [15:0] rdData;
  logic [7:0] status;
  logic rxValid = 1'b0;
  logic [WW-1:0] rxWord = '0;
  logic txValid;
  logic [WW-1:0] txWord;
  logic txReady = 1'b0;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rmesh_node u_rmesh_node (
    .clk(clk), .rstN(rstN), .nodeId(ME), .redundant(redundant), .maskErr(maskErr),
    .busWrEn(busWrEn), .busSel(busSel), .busAddr(busAddr), .busWrData(busWrData),
    .busAck(busAck), .busErr(busErr), .rdAddr(rdAddr), .rdData(rdData),
    .status(status), .rxValid(rxValid), .rxWord(rxWord), .txValid(txValid),
    .txWord(txWord), .txReady(txReady));

  function automatic logic [WW-1:0] mkWord(logic kind, logic [7:0] tag,
                                           logic [7:0] off, logic [15:0] dat);
    logic [WW-2:0] body;
    body = {kind, tag, off, dat};
    return {^body, body};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic sel, logic [7:0] a, logic [15:0] d,
                          output logic ack, output logic err);
    @(negedge clk);
    busWrEn = 1'b1; busSel = sel; busAddr = a; busWrData = d;
    #1; ack = busAck; err = busErr;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic sendRx(logic [WW-1:0] w);
    @(negedge clk);
    rxValid = 1'b1; rxWord = w;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendPair(logic [WW-1:0] a, logic [WW-1:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxWord = a;
    @(negedge clk);
    rxWord = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic readRam(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    d = rdData;
  endtask

  task automatic popTx(output logic [WW-1:0] w, output bit got);
    got = 0; w = '0;
    for (int i = 0; i < 50 && !got; i++) begin
      @(negedge clk);
      if (txValid) begin
        got = 1; w = txWord; txReady = 1'b1;
        @(negedge clk);
        txReady = 1'b0;
      end
    end
  endtask

  task automatic drainTx(int n);
    @(negedge clk); txReady = 1'b1;
    repeat (n) @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlags();
    logic a, e;
    busWrite(1'b1, 8'h00, 16'h0080, a, e);
    drainTx(6);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 reset status", status, 8'hE1);
    check("R11 led resets high", status[7], 1'b1);
    check("R9 tx idle", txValid, 1'b0);
  endtask

  task automatic t_localWrite();
    logic a, e; logic [15:0] d; logic [WW-1:0] w; bit g;
    busWrite(1'b0, 8'd4, 16'hA5A5, a, e);
    check("R1 ack", {a, e}, 2'b10);
    readRam(8'd4, d);
    check("R1 ram", d, 16'hA5A5);
    popTx(w, g);
    check("R1 tx word", {g, w}, {1'b1, mkWord(1'b0, ME, 8'd4, 16'hA5A5)});
    idle(1);
    check("R9 tx empty again", status[4], 1'b0);
  endtask

  task automatic t_foreign();
    logic [15:0] d; logic [WW-1:0] w; bit g;
    sendRx(mkWord(1'b0, OTHER, 8'd20, 16'h0123));
    idle(3);
    readRam(8'd20, d);
    check("R3 stored", d, 16'h0123);
    popTx(w, g);
    check("R3 forwarded", {g, w}, {1'b1, mkWord(1'b0, OTHER, 8'd20, 16'h0123)});
  endtask

  task automatic t_own();
    logic [15:0] d; logic a, e;
    sendRx(mkWord(1'b0, ME, 8'd20, 16'h7777));
    idle(4);
    readRam(8'd20, d);
    check("R2 not stored", d, 16'h0123);
    check("R2 not forwarded", txValid, 1'b0);
    check("R2 own set", status[2], 1'b1);
    idle(5);
    check("R2 own sticky", status[2], 1'b1);
    busWrite(1'b1, 8'h00, 16'h0080, a, e);
    check("R2 own cleared", status[2], 1'b0);
    drainTx(6);
  endtask

  task automatic t_priority();
    logic [WW-1:0] w1, w2, w3; bit g1, g2, g3; logic [15:0] d;
    @(negedge clk);
    rxValid = 1'b1; rxWord = mkWord(1'b0, OTHER, 8'd5, 16'hF00F);
    busWrEn = 1'b1; busSel = 1'b0; busAddr = 8'd4; busWrData = 16'h000A;
    @(negedge clk);
    rxValid = 1'b0;
    busAddr = 8'd5; busWrData = 16'h000B;
    @(negedge clk);
    busWrEn = 1'b0;
    idle(2);
    popTx(w1, g1); popTx(w2, g2); popTx(w3, g3);
    check("R4 first local", w1, mkWord(1'b0, ME, 8'd4, 16'h000A));
    check("R4 second local", w2, mkWord(1'b0, ME, 8'd5, 16'h000B));
    check("R4 forwarded last", w3, mkWord(1'b0, OTHER, 8'd5, 16'hF00F));
    readRam(8'd5, d);
    check("R4 ring write lands last", d, 16'hF00F);
  endtask

  task automatic t_parity();
    logic [15:0] d;
    sendRx(mkWord(1'b0, OTHER, 8'd40, 16'h5555));
    idle(3); drainTx(4);
    sendRx(mkWord(1'b0, OTHER, 8'd40, 16'h6666) ^ 34'h1);
    idle(4);
    check("R5 bad set", status[3], 1'b1);
    check("R5 dropped not forwarded", txValid, 1'b0);
    readRam(8'd40, d);
    check("R5 dropped not stored", d, 16'h5555);
    clearFlags();
    check("R5 bad cleared", status[3], 1'b0);
  endtask

  task automatic t_foreignStatus();
    logic [15:0] d; logic [WW-1:0] w; bit g;
    sendRx(mkWord(1'b0, OTHER, 8'd30, 16'h4444));
    idle(3); drainTx(4);
    sendRx(mkWord(1'b1, OTHER, 8'd30, 16'h0000));
    idle(3);
    check("R10 status untouched", status, 8'hF1);
    popTx(w, g);
    check("R10 forwarded", {g, w}, {1'b1, mkWord(1'b1, OTHER, 8'd30, 16'h0000)});
    readRam(8'd30, d);
    check("R10 ram untouched", d, 16'h4444);
  endtask

  task automatic t_redundant();
    logic a, e; logic [15:0] d; logic [WW-1:0] w1, w2; bit g1, g2;
    @(negedge clk); redundant = 1'b1;
    @(negedge clk);
    check("R9 fast bit low", status[0], 1'b0);
    busWrite(1'b0, 8'd9, 16'h0909, a, e);
    popTx(w1, g1); popTx(w2, g2);
    check("R7 first copy", w1, mkWord(1'b0, ME, 8'd9, 16'h0909));
    check("R7 second copy", w2, mkWord(1'b0, ME, 8'd9, 16'h0909));
    idle(1);
    check("R7 removed after two", txValid, 1'b0);
    sendPair(mkWord(1'b0, OTHER, 8'd10, 16'h1111),
             mkWord(1'b0, OTHER, 8'd10, 16'h2222) ^ 34'h4);
    idle(3);
    readRam(8'd10, d);
    check("R6 keeps good first", d, 16'h1111);
    check("R6 bad on second error", status[3], 1'b1);
    drainTx(6);
    clearFlags();
    sendPair(mkWord(1'b0, OTHER, 8'd11, 16'h3333) ^ 34'h8,
             mkWord(1'b0, OTHER, 8'd11, 16'h3333));
    idle(3);
    readRam(8'd11, d);
    check("R6 falls back to second", d, 16'h3333);
    check("R6 bad on first error", status[3], 1'b1);
    drainTx(8);
    clearFlags();
    @(negedge clk); redundant = 1'b0;
  endtask

  task automatic t_full();
    logic a, e; logic [15:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      busWrite(1'b0, 8'(i), 16'(i), a, e);
      if (i == DEPTH/2 - 1) check("R9 tx half not over", status[5], 1'b1);
      if (i == DEPTH/2)     check("R9 tx over half", status[5], 1'b0);
    end
    busWrite(1'b0, 8'd200, 16'hBEEF, a, e);
    check("R8 refused when full", {a, e}, 2'b01);
    readRam(8'd200, d);
    check("R8 ram unchanged", d, 16'h01C8);
    for (int i = 0; i < DEPTH/2; i++) begin
      sendRx(mkWord(1'b0, OTHER, 8'd60, 16'(i)));
      if (i == DEPTH/2 - 2) check("R9 rx below half", status[6], 1'b1);
    end
    idle(1);
    check("R9 rx half", status[6], 1'b0);
    drainTx(1000);
    check("R9 all drained", status, 8'hE1);
  endtask

  task automatic t_led();
    logic a, e;
    busWrite(1'b1, 8'h00, 16'h0000, a, e);
    check("R11 led off by local write", status[7], 1'b0);
    drainTx(6);
    check("R11 led holds", status[7], 1'b0);
    busWrite(1'b1, 8'h00, 16'h0080, a, e);
    check("R11 led on", status[7], 1'b1);
    drainTx(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_localWrite();
    t_foreign();
    t_own();
    t_priority();
    t_parity();
    t_foreignStatus();
    t_redundant();
    t_full();
    t_led();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule